// File: doc/BRIEF.md
# Prefetch Request Dispatch Filter

This block sits at the head of a prefetch request queue, in front of a pair of split L1 caches, one for instructions and one for data. Each cycle it looks at the request at the head of the queue (a line address and a request type), sends the address to the tag lookups of both caches, and decides one of three outcomes. The request may be dropped because the line is already held in one of the two caches. It may start a fill because the line is absent and the target set has a free way. Or it may force an eviction first, because the target set is full.

It presents at most one event per cycle to the coherence controller. A prefetch event carries the cache that holds or will hold the entry. A replacement event carries the victim address chosen by the target cache. The head of the queue is popped only when a prefetch event is consumed, so a request that forced an eviction is retried later. When the consumed event is a real fill, the block builds the outgoing request message toward the selected L2 bank after a fixed latency. It also holds the enqueue stage through which new prefetch requests enter the queue.

Top module: `pf_dispatch_filter`

## Requirements
- R1: The request type is a 3-bit code: 0 load, 1 store, 2 instruction fetch, 3 atomic. Load maps to event kind 0, instruction fetch to kind 1, and store or atomic to kind 2; kind 3 is replacement. Codes 4 to 7 raise `type_err` and produce no event.
- R2: For an instruction fetch request, a line present in the instruction cache gives a prefetch event against the instruction cache (`evt_in_dcache`=0, `evt_present`=1). Otherwise a line present in the data cache gives the event against the data cache (`evt_in_dcache`=1, `evt_present`=1).
- R3: For a load, store or atomic request, the data cache is searched first and the instruction cache second, with the same present-entry event.
- R4: A line absent from both caches, with a free way in the target cache, gives a prefetch event on the target cache with `evt_present`=0 and `evt_addr` equal to the head address.
- R5: A line absent from both caches, with a full target set, gives a replacement event (kind 3) on the target cache, with `evt_addr` equal to that cache's victim address.
- R6: `head_pop` is high exactly when a prefetch event (kind 0 to 2) is shown and `evt_ready` is high; a replacement event never pops the head.
- R7: While `hp_busy` is high, the block shows no event, no error and no pop.
- R8: A consumed prefetch event with `evt_present`=0 produces one request message exactly REQ_LAT cycles later. Its kind is 0 read-shared for a load, 1 instruction read for a fetch, and 2 read-exclusive for a store or atomic. It carries the line address, and the bank equal to address bits [BANK_LO +: BANK_BITS]. A dropped prefetch sends nothing.
- R9: A request offered on the enqueue input appears on the enqueue output one cycle later with the same address and type, and with the supervisor-mode flag set.
- R10: During reset, no message and no enqueue output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hp_busy | input | 1 | A higher-priority response or forwarded request is ready this cycle |
| head_valid | input | 1 | Prefetch queue head is valid |
| head_addr | input | ADDR_W | Line address of head request |
| head_type | input | 3 | Request type code of head request |
| qry_addr | output | ADDR_W | Address sent to both tag lookups |
| ic_present | input | 1 | Line is valid in instruction cache |
| dc_present | input | 1 | Line is valid in data cache |
| ic_way_free | input | 1 | Instruction cache set has a free way |
| dc_way_free | input | 1 | Data cache set has a free way |
| ic_victim | input | ADDR_W | Victim line of instruction cache set |
| dc_victim | input | ADDR_W | Victim line of data cache set |
| evt_valid | output | 1 | Event shown this cycle |
| evt_kind | output | 2 | 0 load, 1 fetch, 2 store, 3 replacement |
| evt_in_dcache | output | 1 | Event entry is in data cache (else instruction cache) |
| evt_present | output | 1 | Prefetch event refers to an already valid line |
| evt_addr | output | ADDR_W | Head address or victim address |
| evt_ready | input | 1 | Controller consumes the event |
| type_err | output | 1 | Head carries an invalid type code |
| head_pop | output | 1 | Pop the prefetch queue head |
| msg_valid | output | 1 | Outgoing request message valid |
| msg_kind | output | 2 | 0 read-shared, 1 instruction read, 2 read-exclusive |
| msg_addr | output | ADDR_W | Line address of message |
| msg_bank | output | BANK_BITS | Destination L2 bank |
| enq_valid | input | 1 | New prefetch request offered |
| enq_addr | input | ADDR_W | Address of offered request |
| enq_type | input | 3 | Type code of offered request |
| enq_out_valid | output | 1 | Request written toward the queue |
| enq_out_addr | output | ADDR_W | Address written |
| enq_out_type | output | 3 | Type written |
| enq_out_super | output | 1 | Supervisor access mode flag |

## Verification
The bench drives random head requests in which the type, both presence bits, both free-way bits, the busy input and the ready input are drawn each cycle. Presence is biased so that a line is held in both caches, in one only, or in neither. Lines held in both caches tell apart the instruction-first and data-first search orders. Lines held in only the non-target cache show the drop against the wrong cache. Full target sets with `evt_ready` high show that a replacement never pops the head or starts a message, while invalid codes 4 to 7 and busy cycles show that the block stays silent. Consumed fills at scattered addresses check the message delay, its kind and the bank field taken from the address.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   localparam int TYPE_W = 3;

   typedef enum logic [TYPE_W-1:0] {
      RQ_LOAD   = 3'd0,
      RQ_STORE  = 3'd1,
      RQ_FETCH  = 3'd2,
      RQ_ATOMIC = 3'd3
   } rq_type_e;

   typedef enum logic [1:0] {
      EV_PF_LOAD  = 2'd0,
      EV_PF_FETCH = 2'd1,
      EV_PF_STORE = 2'd2,
      EV_REPLACE  = 2'd3
   } ev_kind_e;

   typedef enum logic [1:0] {
      MSG_RD_SHARED = 2'd0,
      MSG_RD_INSTR  = 2'd1,
      MSG_RD_EXCL   = 2'd2
   } msg_kind_e;

endpackage

// File: rtl/pfd_type_decode.sv
module pfd_type_decode
   import pfd_pkg::*;
(
   input  logic [TYPE_W-1:0] rq_type,
   output logic              type_ok,
   output logic              for_icache,
   output ev_kind_e          pf_kind
);

   always_comb begin
      type_ok    = 1'b1;
      for_icache = 1'b0;
      pf_kind    = EV_PF_LOAD;
      case (rq_type)
         RQ_LOAD:   pf_kind = EV_PF_LOAD;
         RQ_FETCH:  begin
            pf_kind    = EV_PF_FETCH;
            for_icache = 1'b1;
         end
         RQ_STORE,
         RQ_ATOMIC: pf_kind = EV_PF_STORE;
         default:   type_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/pfd_route.sv
module pfd_route #(
   parameter int ADDR_W = 32
) (
   input  logic              for_icache,
   input  logic [ADDR_W-1:0] line_addr,
   input  logic              ic_present,
   input  logic              dc_present,
   input  logic              ic_way_free,
   input  logic              dc_way_free,
   input  logic [ADDR_W-1:0] ic_victim,
   input  logic [ADDR_W-1:0] dc_victim,
   output logic              need_evict,
   output logic              in_dcache,
   output logic              present,
   output logic [ADDR_W-1:0] out_addr
);

   logic home_hit, other_hit, home_free;
   logic [ADDR_W-1:0] home_victim;

   // The target cache is searched before the other one.
   assign home_hit    = for_icache ? ic_present  : dc_present;
   assign other_hit   = for_icache ? dc_present  : ic_present;
   assign home_free   = for_icache ? ic_way_free : dc_way_free;
   assign home_victim = for_icache ? ic_victim   : dc_victim;

   always_comb begin
      need_evict = 1'b0;
      present    = 1'b0;
      in_dcache  = !for_icache;
      out_addr   = line_addr;
      if (home_hit) begin
         present = 1'b1;
      end else if (other_hit) begin
         present   = 1'b1;
         in_dcache = for_icache;
      end else if (!home_free) begin
         need_evict = 1'b1;
         out_addr   = home_victim;
      end
   end

endmodule

// File: rtl/pfd_msg_pipe.sv
module pfd_msg_pipe #(
   parameter int ADDR_W    = 32,
   parameter int LAT       = 2,
   parameter int BANK_LO   = 6,
   parameter int BANK_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           in_kind,
   input  logic [ADDR_W-1:0]    in_addr,
   output logic                 out_valid,
   output logic [1:0]           out_kind,
   output logic [ADDR_W-1:0]    out_addr,
   output logic [BANK_BITS-1:0] out_bank
);

   localparam int LAST = LAT - 1;

   logic [LAT-1:0]       st_v;
   logic [1:0]           st_k [LAT];
   logic [ADDR_W-1:0]    st_a [LAT];
   logic [BANK_BITS-1:0] st_b [LAT];

   for (genvar g = 0; g < LAT; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_v[0] <= 1'b0;
            end else begin
               st_v[0] <= in_valid;
            end
            st_k[0] <= in_kind;
            st_a[0] <= in_addr;
            st_b[0] <= in_addr[BANK_LO +: BANK_BITS];
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_v[g] <= 1'b0;
            end else begin
               st_v[g] <= st_v[g-1];
            end
            st_k[g] <= st_k[g-1];
            st_a[g] <= st_a[g-1];
            st_b[g] <= st_b[g-1];
         end
      end
   end

   assign out_valid = st_v[LAST];
   assign out_kind  = st_k[LAST];
   assign out_addr  = st_a[LAST];
   assign out_bank  = st_b[LAST];

endmodule

// File: rtl/pfd_enq_stage.sv
module pfd_enq_stage
   import pfd_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [TYPE_W-1:0] in_type,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [TYPE_W-1:0] out_type,
   output logic              out_super
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_super <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_super <= in_valid;
      end
      out_addr <= in_addr;
      out_type <= in_type;
   end

endmodule

// File: rtl/pf_dispatch_filter.sv
module pf_dispatch_filter
   import pfd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int REQ_LAT   = 2,
   parameter int BANK_LO   = 6,
   parameter int BANK_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hp_busy,
   input  logic                 head_valid,
   input  logic [ADDR_W-1:0]    head_addr,
   input  logic [2:0]           head_type,
   output logic [ADDR_W-1:0]    qry_addr,
   input  logic                 ic_present,
   input  logic                 dc_present,
   input  logic                 ic_way_free,
   input  logic                 dc_way_free,
   input  logic [ADDR_W-1:0]    ic_victim,
   input  logic [ADDR_W-1:0]    dc_victim,
   output logic                 evt_valid,
   output logic [1:0]           evt_kind,
   output logic                 evt_in_dcache,
   output logic                 evt_present,
   output logic [ADDR_W-1:0]    evt_addr,
   input  logic                 evt_ready,
   output logic                 type_err,
   output logic                 head_pop,
   output logic                 msg_valid,
   output logic [1:0]           msg_kind,
   output logic [ADDR_W-1:0]    msg_addr,
   output logic [BANK_BITS-1:0] msg_bank,
   input  logic                 enq_valid,
   input  logic [ADDR_W-1:0]    enq_addr,
   input  logic [2:0]           enq_type,
   output logic                 enq_out_valid,
   output logic [ADDR_W-1:0]    enq_out_addr,
   output logic [2:0]           enq_out_type,
   output logic                 enq_out_super
);

   if (REQ_LAT < 1) begin : g_bad_lat
      $error("REQ_LAT must be at least 1");
   end
   if (BANK_BITS < 1 || BANK_LO + BANK_BITS > ADDR_W) begin : g_bad_bank
      $error("bank field must lie inside the line address");
   end

   logic     type_ok, for_icache, need_evict, rt_dcache, rt_present;
   logic     polled, consume, fill;
   ev_kind_e pf_kind;
   logic [ADDR_W-1:0] rt_addr;

   assign qry_addr = head_addr;
   assign polled   = head_valid && !hp_busy;

   pfd_type_decode u_decode (
      .rq_type    (head_type),
      .type_ok    (type_ok),
      .for_icache (for_icache),
      .pf_kind    (pf_kind)
   );

   pfd_route #(.ADDR_W(ADDR_W)) u_route (
      .for_icache  (for_icache),
      .line_addr   (head_addr),
      .ic_present  (ic_present),
      .dc_present  (dc_present),
      .ic_way_free (ic_way_free),
      .dc_way_free (dc_way_free),
      .ic_victim   (ic_victim),
      .dc_victim   (dc_victim),
      .need_evict  (need_evict),
      .in_dcache   (rt_dcache),
      .present     (rt_present),
      .out_addr    (rt_addr)
   );

   assign evt_valid     = polled && type_ok;
   assign type_err      = polled && !type_ok;
   assign evt_kind      = need_evict ? EV_REPLACE : pf_kind;
   assign evt_in_dcache = rt_dcache;
   assign evt_present   = rt_present;
   assign evt_addr      = rt_addr;

   assign consume  = evt_valid && evt_ready && !need_evict;
   assign head_pop = consume;
   assign fill     = consume && !rt_present;

   pfd_msg_pipe #(
      .ADDR_W(ADDR_W), .LAT(REQ_LAT), .BANK_LO(BANK_LO), .BANK_BITS(BANK_BITS)
   ) u_msg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (fill),
      .in_kind   (pf_kind),
      .in_addr   (head_addr),
      .out_valid (msg_valid),
      .out_kind  (msg_kind),
      .out_addr  (msg_addr),
      .out_bank  (msg_bank)
   );

   pfd_enq_stage #(.ADDR_W(ADDR_W)) u_enq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (enq_valid),
      .in_addr   (enq_addr),
      .in_type   (enq_type),
      .out_valid (enq_out_valid),
      .out_addr  (enq_out_addr),
      .out_type  (enq_out_type),
      .out_super (enq_out_super)
   );

   assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hp_busy |-> !evt_valid && !type_err && !head_pop);

   assert_repl_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_kind == EV_REPLACE) |-> !head_pop);

   assert_pop_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      head_pop |-> evt_ready && evt_valid);

   assert_bad_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !hp_busy && head_type > 3'd3) |-> type_err && !evt_valid);

   assert_msg_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_bank == msg_addr[BANK_LO +: BANK_BITS] && msg_kind != 2'd3);

   assert_enq_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      enq_valid |=> enq_out_valid && enq_out_super && enq_out_addr == $past(enq_addr));

endmodule

// File: tb/pf_dispatch_filter_tb.sv
`timescale 1ns/1ps
module pf_dispatch_filter_tb;

   localparam int AW = 32;
   localparam int LAT = 2;
   localparam int BLO = 6;
   localparam int BB = 2;

   logic clk = 1'b0;
   logic rst_n;
   logic hp_busy, head_valid, ic_present, dc_present, ic_way_free, dc_way_free, evt_ready, enq_valid;
   logic [AW-1:0] head_addr, ic_victim, dc_victim, enq_addr, qry_addr, evt_addr, msg_addr, enq_out_addr;
   logic [2:0] head_type, enq_type, enq_out_type;
   logic evt_valid, evt_in_dcache, evt_present, type_err, head_pop, msg_valid, enq_out_valid, enq_out_super;
   logic [1:0] evt_kind, msg_kind;
   logic [BB-1:0] msg_bank;

   always #4 clk = ~clk;

   pf_dispatch_filter #(.ADDR_W(AW), .REQ_LAT(LAT), .BANK_LO(BLO), .BANK_BITS(BB)) u_dut (.*);

   typedef struct { int due; logic [1:0] kind; logic [AW-1:0] addr; logic [2:0] typ; } pend_t;
   pend_t mq[$];
   pend_t eq[$];
   int checks = 0, errors = 0, cyc = 0;

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   task automatic drive_random();
      logic [3:0] r;
      hp_busy     = ($urandom % 8) == 0;
      head_valid  = ($urandom % 8) != 0;
      r = 4'($urandom % 16);
      head_type   = (r < 4'd14) ? 3'(r % 4) : 3'(4 + (r % 4));
      head_addr   = $urandom;
      ic_present  = ($urandom % 4) == 0;
      dc_present  = ($urandom % 4) == 0;
      ic_way_free = ($urandom % 2) == 0;
      dc_way_free = ($urandom % 2) == 0;
      ic_victim   = $urandom;
      dc_victim   = $urandom;
      evt_ready   = ($urandom % 4) != 0;
      enq_valid   = ($urandom % 2) == 0;
      enq_addr    = $urandom;
      enq_type    = 3'($urandom % 8);
   endtask

   task automatic check_cycle();
      logic ev, er, instr, pres, dsel, ok, pop;
      logic [1:0] kind, base;
      logic [AW-1:0] ea;
      string tg;
      // registered outputs
      if (mq.size() > 0 && mq[0].due == cyc) begin
         chk(msg_valid === 1'b1, "R8 msg valid", msg_valid, 1);
         chk(msg_kind === mq[0].kind, "R8 msg kind", msg_kind, mq[0].kind);
         chk(msg_addr === mq[0].addr, "R8 msg addr", msg_addr, mq[0].addr);
         chk(msg_bank === mq[0].addr[BLO +: BB], "R8 msg bank", msg_bank, mq[0].addr[BLO +: BB]);
         void'(mq.pop_front());
      end else begin
         chk(msg_valid === 1'b0, "R8 no msg", msg_valid, 0);
      end
      if (eq.size() > 0 && eq[0].due == cyc) begin
         chk(enq_out_valid === 1'b1 && enq_out_super === 1'b1, "R9 enq valid/super",
             {enq_out_valid, enq_out_super}, 2'b11);
         chk(enq_out_addr === eq[0].addr && enq_out_type === eq[0].typ, "R9 enq data",
             {enq_out_addr, enq_out_type}, {eq[0].addr, eq[0].typ});
         void'(eq.pop_front());
      end else begin
         chk(enq_out_valid === 1'b0, "R9 no enq", enq_out_valid, 0);
      end
      // reference decision
      ev = 0; er = 0; pres = 0; kind = 0; base = 0; ea = head_addr;
      instr = (head_type == 3'd2);
      dsel = !instr;
      tg = "R7 busy";
      if (head_valid && !hp_busy) begin
         ok = head_type <= 3'd3;
         ev = ok; er = !ok; tg = "R1 type";
         base = (head_type == 3'd0) ? 2'd0 : instr ? 2'd1 : 2'd2;
         kind = base;
         if (instr ? ic_present : dc_present) begin
            pres = 1; tg = instr ? "R2 icache first" : "R3 dcache first";
         end else if (instr ? dc_present : ic_present) begin
            pres = 1; dsel = instr; tg = instr ? "R2 drop in dcache" : "R3 drop in icache";
         end else if (instr ? ic_way_free : dc_way_free) begin
            tg = "R4 fill";
         end else begin
            kind = 2'd3; ea = instr ? ic_victim : dc_victim; tg = "R5 replace";
         end
      end
      pop = ev && evt_ready && kind != 2'd3;
      chk(evt_valid === ev && type_err === er, tg, {evt_valid, type_err}, {ev, er});
      if (ev) begin
         chk(evt_kind === kind, tg, evt_kind, kind);
         chk(evt_in_dcache === dsel && evt_present === pres, tg,
             {evt_in_dcache, evt_present}, {dsel, pres});
         chk(evt_addr === ea, tg, evt_addr, ea);
      end
      chk(head_pop === pop, "R6 pop", head_pop, pop);
      chk(qry_addr === head_addr, "R2 query addr", qry_addr, head_addr);
      if (pop && !pres) mq.push_back('{due: cyc + LAT, kind: base, addr: head_addr, typ: head_type});
      if (enq_valid) eq.push_back('{due: cyc + 1, kind: 2'd0, addr: enq_addr, typ: enq_type});
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      hp_busy = 0; head_valid = 0; head_type = 0; head_addr = 0;
      ic_present = 0; dc_present = 0; ic_way_free = 0; dc_way_free = 0;
      ic_victim = 0; dc_victim = 0; evt_ready = 0; enq_valid = 0; enq_addr = 0; enq_type = 0;
      // reset: pipelines must stay empty even with a consumable fill offered
      repeat (3) @(negedge clk);
      head_valid = 1; evt_ready = 1; dc_way_free = 1;
      repeat (4) begin
         @(negedge clk);
         #1;
         chk(msg_valid === 1'b0 && enq_out_valid === 1'b0, "R10 reset", {msg_valid, enq_out_valid}, 0);
      end
      head_valid = 0; evt_ready = 0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         cyc++;
         drive_random();
         #1;
         check_cycle();
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule